// File: doc/BRIEF.md
# ECC Check-Bit Error Injector

This block sits in a memory controller's write path, between the ECC encoder and the DRAM interface. When software arms it, it deliberately corrupts the check bits or the parity bits of selected write transfers, so that the read-side detection, correction and reporting logic can be tested against errors whose location and shape are known.

Every write carries a decoded DRAM address made of six fields: DIMM slot, rank, channel, bank, page and column. Each field has its own match register, and each of those registers has a wildcard flag. A write is a candidate for corruption only if every field that is not wildcarded equals its programmed value. The check-bit word is split into a low half and a high half. A section code picks one half or both, and a single mask is applied inside each chosen half. Type bits choose whether the check bits, the per-half parity bits or both are corrupted. A further type bit chooses between one-shot operation, where the unit disarms itself after one injection, and repeat operation.

The write stream uses valid/ready and is purely combinational through the block. `mem_valid` follows `wr_valid` and `wr_ready` follows `mem_ready`, so back-pressure from downstream reaches the source in the same cycle. A transfer happens in a cycle where `wr_valid` and `mem_ready` are both high. While the downstream stalls, the source must hold its payload steady. Registers are written through a single-cycle strobe and read back combinationally.

Top module: `ecc_err_inject`

## Requirements
- R1: After reset, each of the six match registers (addresses 0 DIMM, 1 rank, 2 channel, 3 bank, 4 page, 5 column) reads with bit 31 set (the wildcard flag) and a zero value. The mask (6), section (7), type (8) and enable (9) registers read zero.
- R2: Each register reads back what was written, limited to its width. For a match register, the low bits hold the value, truncated to the field width, and bit 31 holds the wildcard flag. The mask register is ECC_W/2 bits wide, the section register 2 bits and the type register 3 bits.
- R3: Writing any nonzero value to the enable register arms the unit, and enable then reads 1. Writing zero disarms it.
- R4: An armed unit corrupts a transfer only when every non-wildcard field equals its programmed value. A single differing field leaves the transfer unchanged. With all fields wildcarded, every address matches.
- R5: Section code 1 selects the low half of `mem_ecc` (bits ECC_W/2-1..0), code 2 the high half, code 3 both halves and code 0 neither. Mask bit k inverts bit k of each selected half, so a mask of 64 flips bit 6 in the low half and bit ECC_W/2+6 in the high half.
- R6: Type bit 1 enables corruption of the check bits. Type bit 2 enables inversion of the parity bit of each selected half: `mem_par` bit 0 belongs to the low half and bit 1 to the high half. The two type bits may be set together.
- R7: With type bit 0 (repeat) clear, the unit injects on one transfer and then disarms itself. Later matching transfers pass unchanged.
- R8: With type bit 0 set, every matching transfer is corrupted until software writes zero to enable.
- R9: The path adds no latency: `mem_valid` equals `wr_valid`, `wr_ready` equals `mem_ready`, and data and address pass unchanged. A stalled cycle (`mem_ready` low) injects nothing and leaves the unit armed.
- R10: `inj_pulse` is high in the cycle after each transfer that was corrupted, and low after any transfer that was not.
- R11: A write to the enable register in the same cycle as a one-shot injection takes precedence over the self-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted |
| wr_dimm | input | DIMM_W | DIMM slot field |
| wr_rank | input | RANK_W | Rank field |
| wr_chan | input | CHAN_W | Channel field |
| wr_bank | input | BANK_W | Bank field |
| wr_page | input | PAGE_W | Page (row) field |
| wr_col | input | COL_W | Column field |
| wr_data | input | DATA_W | Write data |
| wr_ecc | input | ECC_W | Check bits from the encoder |
| wr_par | input | 2 | Parity bit per half |
| mem_valid | output | 1 | Write valid toward memory |
| mem_ready | input | 1 | Memory side can accept |
| mem_addr | output | sum of field widths | {dimm, rank, chan, bank, page, col} |
| mem_data | output | DATA_W | Write data, unchanged |
| mem_ecc | output | ECC_W | Check bits after injection |
| mem_par | output | 2 | Parity bits after injection |
| inj_pulse | output | 1 | One cycle after a corrupted transfer |

## Verification
The bench builds the block with ECC_W=16, which gives 8-bit halves. The single stimulus mask 0x40 therefore lands on bit 6 or bit 14, and that shows which half each section code selected. PAGE_W=12 and COL_W=10 keep the column register narrower than the widest field, so writing all ones shows the truncation. The 1-bit DIMM and channel fields let one stimulus vector flip a single field into a mismatch. The vector table covers every section code, combinations of the type bits and a mismatch in each programmed field. Directed tests then cover reset, one-shot versus repeat operation, a stalled handshake and a collision between a register write and a self-clear.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  localparam int NUM_FIELDS = 6;

  localparam logic [3:0] RA_MASK = 4'd6;
  localparam logic [3:0] RA_SECT = 4'd7;
  localparam logic [3:0] RA_TYPE = 4'd8;
  localparam logic [3:0] RA_ARM  = 4'd9;

  localparam int ANY_BIT    = 31;
  localparam int TYP_REPEAT = 0;
  localparam int TYP_ECC    = 1;
  localparam int TYP_PAR    = 2;

  function automatic int max_of6(int a, int b, int c, int d, int e, int f);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    if (f > m) m = f;
    return m;
  endfunction
endpackage

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs
  import ecc_inj_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int MAX_W  = 12,
  parameter int HALF_W = 8,
  parameter int W_DIMM = 1,
  parameter int W_RANK = 2,
  parameter int W_CHAN = 1,
  parameter int W_BANK = 3,
  parameter int W_PAGE = 12,
  parameter int W_COL  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              inj_fire,
  output logic [MAX_W-1:0]  fld_val [NUM_FIELDS],
  output logic              fld_any [NUM_FIELDS],
  output logic [HALF_W-1:0] ecc_mask,
  output logic [1:0]        sect,
  output logic [2:0]        typ,
  output logic              armed
);
  localparam int FW [NUM_FIELDS] = '{W_DIMM, W_RANK, W_CHAN, W_BANK, W_PAGE, W_COL};

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
    localparam logic [MAX_W-1:0] LIM = MAX_W'((64'd1 << FW[i]) - 64'd1);
    logic [MAX_W-1:0] val_q;
    logic             any_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        val_q <= '0;
        any_q <= 1'b1;
      end else if (cfg_we && cfg_addr == 4'(i)) begin
        val_q <= cfg_wdata[MAX_W-1:0] & LIM;
        any_q <= cfg_wdata[ANY_BIT];
      end
    end
    assign fld_val[i] = val_q;
    assign fld_any[i] = any_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ecc_mask <= '0;
      sect     <= '0;
      typ      <= '0;
      armed    <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == RA_MASK) ecc_mask <= cfg_wdata[HALF_W-1:0];
      if (cfg_we && cfg_addr == RA_SECT) sect     <= cfg_wdata[1:0];
      if (cfg_we && cfg_addr == RA_TYPE) typ      <= cfg_wdata[2:0];
      if (cfg_we && cfg_addr == RA_ARM)
        armed <= |cfg_wdata;
      else if (inj_fire && !typ[TYP_REPEAT])
        armed <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (cfg_addr == 4'(i)) begin
        cfg_rdata[MAX_W-1:0] = fld_val[i];
        cfg_rdata[ANY_BIT]   = fld_any[i];
      end
    end
    case (cfg_addr)
      RA_MASK: cfg_rdata[HALF_W-1:0] = ecc_mask;
      RA_SECT: cfg_rdata[1:0]        = sect;
      RA_TYPE: cfg_rdata[2:0]        = typ;
      RA_ARM:  cfg_rdata[0]          = armed;
      default: ;
    endcase
  end
endmodule

// File: rtl/ecc_inj_match.sv
module ecc_inj_match
  import ecc_inj_pkg::*;
#(
  parameter int MAX_W = 12
) (
  input  logic [MAX_W-1:0] fld_val  [NUM_FIELDS],
  input  logic             fld_any  [NUM_FIELDS],
  input  logic [MAX_W-1:0] addr_fld [NUM_FIELDS],
  output logic             hit
);
  logic [NUM_FIELDS-1:0] fld_ok;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cmp
    assign fld_ok[i] = fld_any[i] || (addr_fld[i] == fld_val[i]);
  end

  assign hit = &fld_ok;
endmodule

// File: rtl/ecc_inj_flip.sv
module ecc_inj_flip
  import ecc_inj_pkg::*;
#(
  parameter int ECC_W = 16
) (
  input  logic               fire,
  input  logic [ECC_W/2-1:0] ecc_mask,
  input  logic [1:0]         sect,
  input  logic [2:0]         typ,
  output logic [ECC_W-1:0]   ecc_flip,
  output logic [1:0]         par_flip
);
  localparam int HALF_W = ECC_W / 2;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic sel;
    assign sel = fire && sect[h];
    assign ecc_flip[h*HALF_W +: HALF_W] = (sel && typ[TYP_ECC]) ? ecc_mask : '0;
    assign par_flip[h] = sel && typ[TYP_PAR];
  end
endmodule

// File: rtl/ecc_err_inject.sv
module ecc_err_inject
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ECC_W  = 16,
  parameter int DIMM_W = 1,
  parameter int RANK_W = 2,
  parameter int CHAN_W = 1,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 12,
  parameter int COL_W  = 10,
  localparam int ADDR_W = DIMM_W + RANK_W + CHAN_W + BANK_W + PAGE_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DIMM_W-1:0] wr_dimm,
  input  logic [RANK_W-1:0] wr_rank,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic [COL_W-1:0]  wr_col,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ECC_W-1:0]  wr_ecc,
  input  logic [1:0]        wr_par,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [ECC_W-1:0]  mem_ecc,
  output logic [1:0]        mem_par,
  output logic              inj_pulse
);
  localparam int HALF_W = ECC_W / 2;
  localparam int MAX_W  = max_of6(DIMM_W, RANK_W, CHAN_W, BANK_W, PAGE_W, COL_W);

  logic [MAX_W-1:0]  fld_val  [NUM_FIELDS];
  logic              fld_any  [NUM_FIELDS];
  logic [MAX_W-1:0]  addr_fld [NUM_FIELDS];
  logic [HALF_W-1:0] ecc_mask;
  logic [1:0]        sect;
  logic [2:0]        typ;
  logic              armed;
  logic              hit;
  logic              xfer;
  logic              inj_fire;
  logic [ECC_W-1:0]  ecc_flip;
  logic [1:0]        par_flip;

  assign addr_fld[0] = MAX_W'(wr_dimm);
  assign addr_fld[1] = MAX_W'(wr_rank);
  assign addr_fld[2] = MAX_W'(wr_chan);
  assign addr_fld[3] = MAX_W'(wr_bank);
  assign addr_fld[4] = MAX_W'(wr_page);
  assign addr_fld[5] = MAX_W'(wr_col);

  ecc_inj_regs #(
    .REG_W(32), .MAX_W(MAX_W), .HALF_W(HALF_W),
    .W_DIMM(DIMM_W), .W_RANK(RANK_W), .W_CHAN(CHAN_W),
    .W_BANK(BANK_W), .W_PAGE(PAGE_W), .W_COL(COL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .inj_fire(inj_fire),
    .fld_val(fld_val), .fld_any(fld_any), .ecc_mask(ecc_mask),
    .sect(sect), .typ(typ), .armed(armed)
  );

  ecc_inj_match #(.MAX_W(MAX_W)) u_match (
    .fld_val(fld_val), .fld_any(fld_any), .addr_fld(addr_fld), .hit(hit)
  );

  assign xfer     = wr_valid && mem_ready;
  assign inj_fire = xfer && armed && hit && (|sect) && (typ[TYP_ECC] || typ[TYP_PAR]);

  ecc_inj_flip #(.ECC_W(ECC_W)) u_flip (
    .fire(inj_fire), .ecc_mask(ecc_mask), .sect(sect), .typ(typ),
    .ecc_flip(ecc_flip), .par_flip(par_flip)
  );

  assign mem_valid = wr_valid;
  assign wr_ready  = mem_ready;
  assign mem_addr  = {wr_dimm, wr_rank, wr_chan, wr_bank, wr_page, wr_col};
  assign mem_data  = wr_data;
  assign mem_ecc   = wr_ecc ^ ecc_flip;
  assign mem_par   = wr_par ^ par_flip;

  always_ff @(posedge clk) begin
    if (!rst_n) inj_pulse <= 1'b0;
    else        inj_pulse <= inj_fire;
  end
endmodule

// File: rtl/ecc_err_inject_chk.sv
module ecc_err_inject_chk #(
  parameter int ECC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [3:0]       cfg_addr,
  input logic [31:0]      cfg_wdata,
  input logic             wr_valid,
  input logic             mem_ready,
  input logic [ECC_W-1:0] wr_ecc,
  input logic [ECC_W-1:0] mem_ecc,
  input logic [1:0]       wr_par,
  input logic [1:0]       mem_par,
  input logic [1:0]       sect,
  input logic [2:0]       typ,
  input logic             armed,
  input logic             hit,
  input logic             inj_pulse
);
  localparam int HALF_W = ECC_W / 2;

  AST_DISARMED_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (mem_ecc == wr_ecc && mem_par == wr_par)); // R3

  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (mem_ecc == wr_ecc && mem_par == wr_par)); // R4

  AST_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sect == 2'd1) |-> (mem_ecc[ECC_W-1:HALF_W] == wr_ecc[ECC_W-1:HALF_W] && mem_par[1] == wr_par[1])); // R5

  AST_HIGH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sect == 2'd2) |-> (mem_ecc[HALF_W-1:0] == wr_ecc[HALF_W-1:0] && mem_par[0] == wr_par[0])); // R5

  AST_STALL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> (mem_ecc == wr_ecc && mem_par == wr_par)); // R9

  AST_PULSE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    inj_pulse |-> $past(wr_valid && mem_ready && armed)); // R10

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_pulse && !$past(typ[0]) && !$past(cfg_we)) |-> !armed); // R7

  AST_ARM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 4'd9 && cfg_wdata != 32'd0) |=> armed); // R11
endmodule

bind ecc_err_inject ecc_err_inject_chk #(.ECC_W(ECC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .wr_valid(wr_valid), .mem_ready(mem_ready),
  .wr_ecc(wr_ecc), .mem_ecc(mem_ecc), .wr_par(wr_par), .mem_par(mem_par),
  .sect(sect), .typ(typ), .armed(armed), .hit(hit), .inj_pulse(inj_pulse)
);

// File: tb/ecc_err_inject_bench.sv
module ecc_err_inject_bench;
  localparam int DATA_W = 32;
  localparam int ECC_W  = 16;
  localparam int PAGE_W = 12;
  localparam int COL_W  = 10;
  localparam int ADDR_W = 1 + 2 + 1 + 3 + PAGE_W + COL_W;
  localparam logic [15:0] ECC_IN = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic wr_valid = 1'b0, wr_ready;
  logic [0:0] wr_dimm = '0;
  logic [1:0] wr_rank = '0;
  logic [0:0] wr_chan = '0;
  logic [2:0] wr_bank = '0;
  logic [PAGE_W-1:0] wr_page = '0;
  logic [COL_W-1:0] wr_col = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [ECC_W-1:0] wr_ecc = '0;
  logic [1:0] wr_par = '0;
  logic mem_valid, mem_ready = 1'b1;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data;
  logic [ECC_W-1:0] mem_ecc;
  logic [1:0] mem_par;
  logic inj_pulse;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ecc_err_inject #(.DATA_W(DATA_W), .ECC_W(ECC_W), .PAGE_W(PAGE_W), .COL_W(COL_W)) u_ecc_err_inject (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_dimm(wr_dimm),
    .wr_rank(wr_rank), .wr_chan(wr_chan), .wr_bank(wr_bank), .wr_page(wr_page), .wr_col(wr_col),
    .wr_data(wr_data), .wr_ecc(wr_ecc), .wr_par(wr_par), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .mem_ecc(mem_ecc),
    .mem_par(mem_par), .inj_pulse(inj_pulse)
  );

  // dimm, rank, bank, col, section, type, expected ecc xor, expected parity xor
  typedef struct packed {
    logic [0:0]  dimm;
    logic [1:0]  rank;
    logic [2:0]  bank;
    logic [9:0]  col;
    logic [1:0]  sect;
    logic [2:0]  typ;
    logic [15:0] exp_ecc;
    logic [1:0]  exp_par;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b1, 2'd2, 3'd5, 10'h03A, 2'd1, 3'd3, 16'h0040, 2'b00},
    '{1'b1, 2'd2, 3'd5, 10'h03A, 2'd2, 3'd3, 16'h4000, 2'b00},
    '{1'b1, 2'd2, 3'd5, 10'h03A, 2'd3, 3'd3, 16'h4040, 2'b00},
    '{1'b1, 2'd2, 3'd5, 10'h03A, 2'd3, 3'd5, 16'h0000, 2'b11},
    '{1'b1, 2'd2, 3'd5, 10'h03A, 2'd1, 3'd7, 16'h0040, 2'b01},
    '{1'b1, 2'd2, 3'd5, 10'h03A, 2'd0, 3'd7, 16'h0000, 2'b00},
    '{1'b0, 2'd2, 3'd5, 10'h03A, 2'd3, 3'd7, 16'h0000, 2'b00},
    '{1'b1, 2'd1, 3'd5, 10'h03A, 2'd3, 3'd7, 16'h0000, 2'b00},
    '{1'b1, 2'd2, 3'd4, 10'h03A, 2'd3, 3'd7, 16'h0000, 2'b00},
    '{1'b1, 2'd2, 3'd5, 10'h03B, 2'd3, 3'd7, 16'h0000, 2'b00},
    '{1'b1, 2'd2, 3'd5, 10'h03A, 2'd2, 3'd6, 16'h4000, 2'b10},
    '{1'b1, 2'd2, 3'd5, 10'h03A, 2'd3, 3'd1, 16'h0000, 2'b00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  // One transfer; returns the xor applied to ecc/parity and the pulse seen afterwards.
  task automatic xfer(input logic [0:0] dm, input logic [1:0] rk, input logic [0:0] ch,
                      input logic [2:0] bk, input logic [PAGE_W-1:0] pg, input logic [9:0] cl,
                      output logic [15:0] dx, output logic [1:0] px, output logic pls);
    @(negedge clk);
    wr_dimm = dm; wr_rank = rk; wr_chan = ch; wr_bank = bk; wr_page = pg; wr_col = cl;
    wr_ecc = ECC_IN; wr_par = 2'b01; wr_data = 32'hC0DE_0000 | 32'(cl);
    wr_valid = 1'b1;
    #2;
    dx = mem_ecc ^ wr_ecc;
    px = mem_par ^ wr_par;
    @(negedge clk);
    wr_valid = 1'b0;
    pls = inj_pulse;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] dx;
    logic [1:0]  px;
    logic        pls;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      cfg_rd(4'(i), rd);
      chk("R1 field wildcard", rd, 32'h8000_0000);
    end
    for (int i = 6; i < 10; i++) begin
      cfg_rd(4'(i), rd);
      chk("R1 ctrl zero", rd, 32'h0);
    end

    // R4 all-wildcard match, R5/R6 both halves
    cfg_wr(4'd6, 32'h1);
    cfg_wr(4'd7, 32'd3);
    cfg_wr(4'd8, 32'd3);
    cfg_wr(4'd9, 32'd1);
    xfer(1'b0, 2'd3, 1'b1, 3'd7, 12'hABC, 10'h155, dx, px, pls);
    chk("R4 wildcard match ecc", 32'(dx), 32'h0101);

    // R3 arm/disarm readback
    cfg_wr(4'd9, 32'h10);
    cfg_rd(4'd9, rd);
    chk("R3 armed", rd, 32'd1);
    cfg_wr(4'd9, 32'h0);
    cfg_rd(4'd9, rd);
    chk("R3 disarmed", rd, 32'd0);
    xfer(1'b0, 2'd0, 1'b0, 3'd0, 12'h0, 10'h0, dx, px, pls);
    chk("R3 disarmed passes", 32'(dx), 32'h0);

    // R2 readback widths
    cfg_wr(4'd5, 32'h0000_FFFF);
    cfg_rd(4'd5, rd);
    chk("R2 column truncated", rd, 32'h0000_03FF);
    cfg_wr(4'd6, 32'h1FF);
    cfg_rd(4'd6, rd);
    chk("R2 mask width", rd, 32'h0000_00FF);
    cfg_wr(4'd8, 32'hF);
    cfg_rd(4'd8, rd);
    chk("R2 type width", rd, 32'h7);

    // Table setup: dimm=1 rank=2 bank=5 col=0x3A, channel/page wildcard, mask 64
    cfg_wr(4'd0, 32'd1);
    cfg_wr(4'd1, 32'd2);
    cfg_wr(4'd3, 32'd5);
    cfg_wr(4'd5, 32'h3A);
    cfg_wr(4'd6, 32'd64);
    for (int v = 0; v < 12; v++) begin
      cfg_wr(4'd7, 32'(VEC[v].sect));
      cfg_wr(4'd8, 32'(VEC[v].typ));
      cfg_wr(4'd9, 32'd1);
      xfer(VEC[v].dimm, VEC[v].rank, 1'(v), VEC[v].bank, 12'(v * 37), VEC[v].col, dx, px, pls);
      chk("R4 R5 R6 table ecc", 32'(dx), 32'(VEC[v].exp_ecc));
      chk("R6 table parity", 32'(px), 32'(VEC[v].exp_par));
      chk("R10 table pulse", 32'(pls), 32'((VEC[v].exp_ecc != 0) || (VEC[v].exp_par != 0)));
    end

    // R7 one-shot
    cfg_wr(4'd7, 32'd1);
    cfg_wr(4'd8, 32'd2);
    cfg_wr(4'd9, 32'd1);
    xfer(1'b1, 2'd2, 1'b0, 3'd5, 12'h0, 10'h3A, dx, px, pls);
    chk("R7 first injects", 32'(dx), 32'h0040);
    cfg_rd(4'd9, rd);
    chk("R7 self disarm", rd, 32'd0);
    xfer(1'b1, 2'd2, 1'b0, 3'd5, 12'h0, 10'h3A, dx, px, pls);
    chk("R7 second clean", 32'(dx), 32'h0);
    chk("R10 no pulse", 32'(pls), 32'd0);

    // R8 repeat
    cfg_wr(4'd8, 32'd3);
    cfg_wr(4'd9, 32'd1);
    for (int k = 0; k < 3; k++) begin
      xfer(1'b1, 2'd2, 1'b1, 3'd5, 12'(k), 10'h3A, dx, px, pls);
      chk("R8 repeat injects", 32'(dx), 32'h0040);
      chk("R10 repeat pulse", 32'(pls), 32'd1);
    end
    cfg_rd(4'd9, rd);
    chk("R8 still armed", rd, 32'd1);

    // R9 stall and passthrough
    cfg_wr(4'd8, 32'd2);
    @(negedge clk);
    mem_ready = 1'b0;
    xfer(1'b1, 2'd2, 1'b0, 3'd5, 12'h5A5, 10'h3A, dx, px, pls);
    chk("R9 stall no flip", 32'(dx), 32'h0);
    chk("R9 stall no pulse", 32'(pls), 32'd0);
    cfg_rd(4'd9, rd);
    chk("R9 stall stays armed", rd, 32'd1);
    @(negedge clk);
    wr_valid = 1'b1;
    #1;
    chk("R9 ready follows", 32'(wr_ready), 32'd0);
    chk("R9 valid follows", 32'(mem_valid), 32'd1);
    chk("R9 addr pass", 32'(mem_addr), {5'd0, 1'b1, 2'd2, 1'b0, 3'd5, 12'h5A5, 10'h03A});
    chk("R9 data pass", mem_data, 32'hC0DE_003A);
    mem_ready = 1'b1;
    wr_valid = 1'b0;

    // R11 arm write collides with one-shot injection
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd9; cfg_wdata = 32'd1;
    wr_dimm = 1'b1; wr_rank = 2'd2; wr_bank = 3'd5; wr_col = 10'h3A; wr_ecc = ECC_IN;
    wr_valid = 1'b1;
    #2 dx = mem_ecc ^ wr_ecc;
    @(negedge clk);
    cfg_we = 1'b0; wr_valid = 1'b0;
    chk("R11 collision injects", 32'(dx), 32'h0040);
    cfg_rd(4'd9, rd);
    chk("R11 write wins", rd, 32'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule